// File: doc/BRIEF.md
# Two-Pass 8x8 Inverse Transform Datapath

This block turns one 8x8 block of dequantized frequency coefficients into an 8x8 block of signed 8-bit spatial samples. It applies a separable inverse cosine transform in two passes and has a single time-shared multiplier. The block first takes in all 64 coefficients. The first pass then works down the columns and writes a 13-bit intermediate matrix. The second pass reads that matrix across its rows and emits the final samples. Each output value is an 8-term dot product. Each partial sum keeps only its most significant 17 bits when it is fed back to the adder.

The basis matrix is built into the block as 32 words of two 13-bit entries each. The first pass uses full 13-bit entries. The second pass uses only the upper 12 bits of each entry. The final stage takes the top 10 bits of the second-pass sum, halves them arithmetically and saturates the result to -128..127. A block takes 64 load cycles and then 1024 compute cycles. The next block can be loaded once the last sample of the current one has come out.

Top module: `idct2p`

## Requirements
- R1: While reset is active and directly after it, `in_ready` is 1, and `out_valid` and `done` are 0.
- R2: While `in_ready` is 1, each cycle with `in_valid` high stores one coefficient. The 64 coefficients arrive in row-major order: index 8*v+u, where v is the vertical frequency and u the horizontal frequency. `in_ready` goes low in the cycle after the 64th coefficient is taken.
- R3: The basis entry M[k][n] (k is the frequency, n the position) is 2896 for k=0. Otherwise let a=((2n+1)*k) mod 32. The value is T(a) for a<=8, -T(16-a) for 8<a<=16, -T(a-16) for 16<a<=24, and T(32-a) above 24. The table is T = 4096, 4017, 3784, 3406, 2896, 2276, 1567, 799, 0 for a = 0..8. Entry 8k+n is held in word (8k+n)/2: even indices in bits 12:0, odd indices in bits 25:13.
- R4: First pass, for column u and output row y: the 8 terms r=0..7 are C[8r+u]*M[r][y]. The running sum S is 26-bit two's complement: S=P0 at r=0, and S=P+F*512 after that, where F=S>>>9 from the previous term. The intermediate value I[y][u] is S>>>13, taken as 13 bits.
- R5: Second pass, for row y and output column x: the 8 terms c=0..7 are I[y][c]*(M[c][x]>>>1). The running sum is 21-bit two's complement: S=P0 at c=0, and S=P+F*16 after that, where F=S>>>4 from the previous term.
- R6: Each sample is the top 10 bits of the final second-pass sum (S>>>11), shifted right arithmetically by one (rounding toward minus infinity) and saturated to -128..127.
- R7: The 64 samples come out in row-major order (index 8y+x), one `out_valid` cycle every 8 clock cycles.
- R8: `done` is high for one cycle, together with the 64th sample. `in_ready` is 1 from that same cycle on.
- R9: A high `in_valid` while `in_ready` is 0 is ignored. It changes neither the block being computed nor the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Coefficient present |
| in_data | input | 12 | Signed coefficient |
| in_ready | output | 1 | Block is loading coefficients |
| out_valid | output | 1 | Sample present |
| out_data | output | 8 | Signed output sample |
| done | output | 1 | Last sample of the block |

## Verification
An all-zero block checks that no residue is left over between blocks. Blocks with only a DC term show the overall scaling and the floor rounding of small negative values. Extreme DC values of both signs drive the saturation at +127 and at -128. Single-AC and checkerboard blocks exercise the matrix signs and the transposed order of the buffer. Pseudo-random blocks mix all of these, and a stream of junk coefficients offered while the block is busy shows whether anything is taken outside the load window.

// File: rtl/idct2p.sv
module idct2p (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic signed [11:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic signed [7:0] out_data,
  output logic              done
);
  typedef enum logic [1:0] {S_LOAD, S_P1, S_P2} st_t;

  st_t st;
  logic [5:0] cnt;
  logic [2:0] k;
  logic signed [16:0] fb;

  logic signed [11:0] xbuf [64];
  logic signed [12:0] ibuf [64];

  function automatic logic signed [12:0] ment(input logic [5:0] idx);
    logic [2:0] fk, fn;
    logic [4:0] a;
    logic neg;
    logic signed [12:0] v;
    fk = idx[5:3];
    fn = idx[2:0];
    a = 5'(({fn, 1'b1}) * fk);
    if (a > 5'd16) a = 5'(6'd32 - {1'b0, a});
    neg = (a > 5'd8);
    if (neg) a = 5'd16 - a;
    case (a[3:0])
      4'd0:    v = 13'sd4095;
      4'd1:    v = 13'sd4017;
      4'd2:    v = 13'sd3784;
      4'd3:    v = 13'sd3406;
      4'd4:    v = 13'sd2896;
      4'd5:    v = 13'sd2276;
      4'd6:    v = 13'sd1567;
      4'd7:    v = 13'sd799;
      default: v = 13'sd0;
    endcase
    if (fk == 3'd0) v = 13'sd2896;
    return neg ? -v : v;
  endfunction

  function automatic logic [25:0] rom_word(input logic [4:0] w);
    return {ment({w, 1'b1}), ment({w, 1'b0})};
  endfunction

  logic p1;
  logic first;
  logic [5:0] ridx;
  logic [25:0] rword;
  logic signed [12:0] rent, mul_a, mul_b;
  logic signed [25:0] prod;
  logic [25:0] s1;
  logic [20:0] s2;
  logic signed [8:0] half;
  logic signed [7:0] sat;

  assign p1 = (st == S_P1);
  assign first = (k == 3'd0);
  assign ridx = {k, cnt[2:0]};
  assign rword = rom_word(ridx[5:1]);
  assign rent = ridx[0] ? rword[25:13] : rword[12:0];
  assign mul_a = p1 ? {xbuf[{k, cnt[5:3]}][11], xbuf[{k, cnt[5:3]}]} : ibuf[{cnt[5:3], k}];
  assign mul_b = p1 ? rent : {rent[12], rent[12:1]};
  assign prod = mul_a * mul_b;
  assign s1 = prod + (first ? 26'd0 : {fb, 9'd0});
  assign s2 = prod[20:0] + (first ? 21'd0 : {fb, 4'd0});
  assign half = s2[20:12];
  assign sat = (half[8] != half[7]) ? (half[8] ? -8'sd128 : 8'sd127) : half[7:0];
  assign in_ready = (st == S_LOAD);

  always_ff @(posedge clk) begin
    if (st == S_LOAD && in_valid) xbuf[cnt] <= in_data;
    if (p1 && k == 3'd7) ibuf[{cnt[2:0], cnt[5:3]}] <= s1[25:13];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_LOAD;
      cnt <= '0;
      k <= '0;
      fb <= '0;
      out_valid <= 1'b0;
      out_data <= '0;
      done <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      done <= 1'b0;
      if (st == S_LOAD) begin
        k <= '0;
        if (in_valid) begin
          cnt <= cnt + 6'd1;
          if (cnt == 6'd63) st <= S_P1;
        end
      end else begin
        k <= k + 3'd1;
        fb <= p1 ? s1[25:9] : s2[20:4];
        if (k == 3'd7) begin
          cnt <= cnt + 6'd1;
          if (!p1) begin
            out_valid <= 1'b1;
            out_data <= sat;
            done <= (cnt == 6'd63);
          end
          if (cnt == 6'd63) st <= p1 ? S_P2 : S_LOAD;
        end
      end
    end
  end
endmodule

module idct2p_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic done
);
  p_wait_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);
  p_start_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> !out_valid);
  p_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_done_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_valid && in_ready));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind idct2p idct2p_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .done(done)
);

// File: tb/idct2p_tb.sv
module idct2p_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [11:0] in_data = '0;
  logic in_ready, out_valid, done;
  logic signed [7:0] out_data;

  always #5 clk = ~clk;

  idct2p u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data), .done(done)
  );

  int n_chk = 0, n_fail = 0;
  int cin [64];
  int ev [64];
  int sidx = 0;
  int cyc = 0, last_cyc = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int tabv(int a);
    case (a)
      0: return 4096; 1: return 4017; 2: return 3784; 3: return 3406;
      4: return 2896; 5: return 2276; 6: return 1567; 7: return 799;
      default: return 0;
    endcase
  endfunction

  function automatic int bm(int kk, int nn);
    int a = ((2 * nn + 1) * kk) % 32;
    if (kk == 0) return 2896;
    if (a <= 8) return tabv(a);
    if (a <= 16) return -tabv(16 - a);
    if (a <= 24) return -tabv(a - 16);
    return tabv(32 - a);
  endfunction

  function automatic int wr(int v, int w);
    int m = v & ((1 << w) - 1);
    if (m >= (1 << (w - 1))) m = m - (1 << w);
    return m;
  endfunction

  task automatic model();
    int im [64];
    int s, f, p, h;
    for (int u = 0; u < 8; u++)
      for (int y = 0; y < 8; y++) begin
        f = 0;
        for (int r = 0; r < 8; r++) begin
          p = cin[8*r+u] * bm(r, y);
          s = wr((r == 0) ? p : p + f * 512, 26);
          f = s >>> 9;
        end
        im[8*y+u] = wr(s >>> 13, 13);
      end
    for (int y = 0; y < 8; y++)
      for (int x = 0; x < 8; x++) begin
        f = 0;
        for (int c = 0; c < 8; c++) begin
          p = im[8*y+c] * (bm(c, x) >>> 1);
          s = wr((c == 0) ? p : p + f * 16, 21);
          f = s >>> 4;
        end
        h = (s >>> 11) >>> 1;
        if (h > 127) h = 127;
        if (h < -128) h = -128;
        ev[8*y+x] = h;
      end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && done && !out_valid) chk(0, "R8 done without sample", 1, 0);
    if (rst_n && out_valid) begin
      chk(out_data == ev[sidx[5:0]], "R4 R5 R6 sample value", out_data, ev[sidx[5:0]]);
      if (sidx > 0) chk(cyc - last_cyc == 8, "R7 sample spacing", cyc - last_cyc, 8);
      chk(done == (sidx == 63), "R8 done position", done, sidx == 63);
      if (done) chk(in_ready == 1'b1, "R8 ready with done", in_ready, 1);
      last_cyc = cyc;
      sidx++;
    end
  end

  task automatic run_block(input string tag);
    model();
    sidx = 0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R2 ready before load", in_ready, 1);
    for (int i = 0; i < 64; i++) begin
      in_valid = 1'b1;
      in_data = 12'(cin[i]);
      @(negedge clk);
    end
    chk(in_ready == 1'b0, "R2 ready drops after 64", in_ready, 0);
    in_valid = 1'b1;
    in_data = 12'sh7ff;
    forever begin
      @(negedge clk);
      if (in_ready) break;
      in_data = ~in_data;
    end
    in_valid = 1'b0;
    @(posedge clk);
    chk(sidx == 64, {"R7 sample count ", tag}, sidx, 64);
  endtask

  task automatic clear();
    for (int i = 0; i < 64; i++) cin[i] = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0 && done == 1'b0, "R1 in reset", {in_ready, out_valid, done}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0 && done == 1'b0, "R1 after reset", {in_ready, out_valid, done}, 3'b100);

    clear(); run_block("zero");
    clear(); cin[0] = 800; run_block("dc pos");
    clear(); cin[0] = -9; run_block("dc floor");
    clear(); cin[0] = 2047; run_block("clamp high R6");
    clear(); cin[0] = -2048; run_block("clamp low R6");
    clear(); cin[1] = 500; run_block("ac horiz R3");
    clear(); cin[8] = -500; run_block("ac vert R3");
    clear(); cin[63] = 700; cin[9] = 300; run_block("ac high R3");
    for (int i = 0; i < 64; i++) cin[i] = (((i >> 3) ^ i) & 1) ? 90 : -90;
    run_block("checker");
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < 64; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cin[i] = int'($signed(lfsr[7:0]));
      end
      cin[0] = cin[0] * 4;
      run_block("random R9");
    end

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule